// File: doc/BRIEF.md
# Big-Endian Load/Store Address Unit

This block turns one decoded memory instruction into a single memory request. It forms the effective address, places store data on the correct byte lanes of a word-wide bus, and writes back the load result zero-extended to the full data width. For stack pushes and pops it also produces the new stack pointer value. The caller supplies the two register values named by the instruction's low byte: the "high" register comes from bits 7:4 and the "low" register from bits 3:0. It also supplies the extension bytes that follow the instruction, in address order. The block reports the total instruction length so that the program counter can advance.

Every memory access, loads and stores alike, goes through a valid/ready request and then a response. Four enumerated states control the sequence. In IDLE, a start pulse latches the resolved command and moves to REQ. REQ holds the request until the memory accepts it, then moves to RSP. RSP waits for the response, captures load data, and moves to DONE. DONE is a one-cycle completion pulse and then returns to IDLE. A start pulse in any state other than IDLE is ignored.

Bus lanes are big-endian. The byte at offset k within a word (address bits 1:0) sits on bits [31-8k:24-8k], and byte enable bit (3-k) marks it. A halfword at address bit 1 = 0 uses lanes 31:16, and one at address bit 1 = 1 uses lanes 15:0.

Top module: `be_lsu_agu`

## Requirements
- R1: In absolute mode (cmd_mode=0), the address is the 32-bit word built from the four extension bytes, with ext_bytes[7:0] (the lowest address) as the most significant byte and ext_bytes[31:24] as the least. The instruction length is 6.
- R2: In offset mode (cmd_mode=2), the offset is the 16-bit value {ext_bytes[7:0], ext_bytes[15:8]}, sign-extended to 32 bits. Loads add it to reg_lo and stores add it to reg_hi. The instruction length is 4.
- R3: In register-indirect mode (cmd_mode=1), loads address memory with reg_lo and stores with reg_hi. The instruction length is 2.
- R4: Store data comes from reg_hi in absolute mode and from reg_lo otherwise. It is placed on the big-endian lanes for its size (cmd_size 0=byte, 1=halfword, 2=word). Unselected lanes are zero, mem_be marks exactly the selected lanes, and mem_size repeats the size code.
- R5: Load data is taken from the big-endian lanes for the size and address. Byte and halfword results are zero-extended. The destination is the bit 7:4 register, so ld_to_lo=0.
- R6: A push (cmd_op=2) writes reg_lo as a word to reg_hi-4, whatever cmd_size and cmd_mode hold. It sets sp_we with sp_new = reg_hi-4, and the length is 2.
- R7: A pop (cmd_op=3) reads a word from reg_hi into the bit 3:0 register (ld_to_lo=1). It sets sp_we with sp_new = reg_hi+4, and the length is 2.
- R8: Loads (cmd_op=0) drive mem_we=0, and stores and pushes drive mem_we=1.
- R9: mem_req_valid and the request fields hold steady until mem_req_ready. done pulses for exactly one cycle, in the cycle after the response is accepted, and never before.
- R10: A start pulse while a command is in flight is ignored. It changes neither the request nor the result, and no request follows it.
- R11: After reset, no request is pending, done is low and ld_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept the command on the cmd_* inputs (only in IDLE) |
| cmd_op | input | 2 | 0 load, 1 store, 2 push, 3 pop |
| cmd_mode | input | 2 | 0 absolute, 1 register indirect, 2 register plus offset |
| cmd_size | input | 2 | 0 byte, 1 halfword, 2 word |
| reg_hi | input | 32 | Value of the register named in instruction bits 7:4 |
| reg_lo | input | 32 | Value of the register named in instruction bits 3:0 |
| ext_bytes | input | 32 | Extension bytes; bits 7:0 at the lowest address |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address of the access |
| mem_we | output | 1 | 1 for write |
| mem_size | output | 2 | Access size code |
| mem_be | output | 4 | Byte-lane enables, bit i covers bits 8i+7:8i |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_rdata | input | 32 | Lane-aligned read data |
| done | output | 1 | One-cycle completion pulse |
| ld_data | output | 32 | Extended load result |
| ld_to_lo | output | 1 | Load destination: 0 bits 7:4 register, 1 bits 3:0 register |
| sp_we | output | 1 | Stack register update valid |
| sp_new | output | 32 | New stack register value |
| inst_len | output | 4 | Instruction length in bytes |

## Verification
The embedded properties watch the handshake on every cycle. They check that a stalled request keeps its address and data, that done is a single pulse following an accepted response, that done never overlaps a request, and that a stray start leaves the request unchanged. On every request they also check that the lane-enable count matches the size code and that the stack update agrees with the push or pop address. The address arithmetic cannot be seen from those cycle relations and only the bench scenarios can show it. That covers big-endian assembly of the extension bytes, sign extension of negative and maximum offsets, which register serves as base or data in each mode, lane placement at each byte offset, and zero extension of loaded bytes and halfwords.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_PUSH  = 2'd2,
        OP_POP   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        AM_ABS = 2'd0,
        AM_IND = 2'd1,
        AM_OFS = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2,
        ST_DONE = 2'd3
    } state_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16,
    parameter int LEN_W  = 4
) (
    input  op_e               op,
    input  mode_e             mode,
    input  size_e             size,
    input  logic [DATA_W-1:0] reg_hi,
    input  logic [DATA_W-1:0] reg_lo,
    input  logic [DATA_W-1:0] ext,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] store_val,
    output logic [DATA_W-1:0] sp_new,
    output logic              sp_we,
    output logic              dest_lo,
    output logic              is_write,
    output size_e             eff_size,
    output logic [LEN_W-1:0]  len
);
    localparam int NB       = DATA_W / 8;
    localparam int BASE_LEN = 2;
    localparam int ABS_LEN  = BASE_LEN + NB;
    localparam int OFS_LEN  = BASE_LEN + OFS_W / 8;

    logic [DATA_W-1:0] abs_word;
    logic [DATA_W-1:0] ofs_ext;

    // Lowest-addressed extension byte becomes the most significant byte.
    for (genvar gi = 0; gi < NB; gi++) begin : g_be_asm
        assign abs_word[DATA_W-1-8*gi -: 8] = ext[8*gi +: 8];
    end

    // The offset form uses only the first OFS_W/8 bytes, again MSB first.
    assign ofs_ext = {{(DATA_W-OFS_W){abs_word[DATA_W-1]}}, abs_word[DATA_W-1 -: OFS_W]};

    always_comb begin
        addr      = reg_lo;
        store_val = reg_lo;
        sp_new    = reg_hi;
        sp_we     = 1'b0;
        dest_lo   = 1'b0;
        is_write  = 1'b0;
        eff_size  = size;
        len       = LEN_W'(BASE_LEN);
        unique case (op)
            OP_LOAD: begin
                case (mode)
                    AM_ABS: begin
                        addr = abs_word;
                        len  = LEN_W'(ABS_LEN);
                    end
                    AM_OFS: begin
                        addr = reg_lo + ofs_ext;
                        len  = LEN_W'(OFS_LEN);
                    end
                    default: addr = reg_lo;
                endcase
            end
            OP_STORE: begin
                is_write = 1'b1;
                case (mode)
                    AM_ABS: begin
                        addr      = abs_word;
                        store_val = reg_hi;
                        len       = LEN_W'(ABS_LEN);
                    end
                    AM_OFS: begin
                        addr = reg_hi + ofs_ext;
                        len  = LEN_W'(OFS_LEN);
                    end
                    default: addr = reg_hi;
                endcase
            end
            OP_PUSH: begin
                is_write = 1'b1;
                addr     = reg_hi - DATA_W'(NB);
                sp_new   = reg_hi - DATA_W'(NB);
                sp_we    = 1'b1;
                eff_size = SZ_WORD;
            end
            OP_POP: begin
                addr     = reg_hi;
                sp_new   = reg_hi + DATA_W'(NB);
                sp_we    = 1'b1;
                dest_lo  = 1'b1;
                eff_size = SZ_WORD;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e                       size,
    input  logic [$clog2(DATA_W/8)-1:0] ofs,
    input  logic [DATA_W-1:0]           store_val,
    input  logic [DATA_W-1:0]           rdata,
    output logic [DATA_W-1:0]           wdata,
    output logic [DATA_W/8-1:0]         be,
    output logic [DATA_W-1:0]           ld_val
);
    localparam int NB = DATA_W / 8;
    localparam int LB = $clog2(NB);

    // Lane gi carries the byte at offset NB-1-gi (big-endian).
    for (genvar gi = 0; gi < NB; gi++) begin : g_lane
        localparam int K = NB - 1 - gi;
        logic       hit;
        logic [7:0] lane_val;

        always_comb begin
            case (size)
                SZ_BYTE: begin
                    hit      = (ofs == LB'(K));
                    lane_val = store_val[7:0];
                end
                SZ_HALF: begin
                    hit      = ((ofs >> 1) == LB'(K >> 1));
                    lane_val = ((K % 2) == 0) ? store_val[15:8] : store_val[7:0];
                end
                default: begin
                    hit      = 1'b1;
                    lane_val = store_val[8*gi +: 8];
                end
            endcase
        end

        assign be[gi]          = hit;
        assign wdata[8*gi +: 8] = hit ? lane_val : 8'h00;
    end

    logic [7:0]  ld_b;
    logic [15:0] ld_h;

    always_comb begin
        ld_b = 8'h00;
        ld_h = 16'h0000;
        for (int i = 0; i < NB; i++) begin
            if (be[i]) begin
                ld_b = ld_b | rdata[8*i +: 8];
                if (((NB - 1 - i) % 2) == 0) ld_h[15:8] = ld_h[15:8] | rdata[8*i +: 8];
                else                         ld_h[7:0]  = ld_h[7:0]  | rdata[8*i +: 8];
            end
        end
        case (size)
            SZ_BYTE: ld_val = {{(DATA_W-8){1'b0}}, ld_b};
            SZ_HALF: ld_val = {{(DATA_W-16){1'b0}}, ld_h};
            default: ld_val = rdata;
        endcase
    end

endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
    import lsu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   req_ready,
    input  logic   rsp_valid,
    output state_e state,
    output logic   accept_cmd,
    output logic   req_valid,
    output logic   capture,
    output logic   done
);
    state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_REQ;
            ST_REQ:  if (req_ready) state_d = ST_RSP;
            ST_RSP:  if (rsp_valid) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state      = state_q;
        accept_cmd = (state_q == ST_IDLE) && start;
        req_valid  = (state_q == ST_REQ);
        capture    = (state_q == ST_RSP) && rsp_valid;
        done       = (state_q == ST_DONE);
    end

endmodule

// File: rtl/be_lsu_agu.sv
module be_lsu_agu
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16,
    parameter int LEN_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          cmd_op,
    input  logic [1:0]          cmd_mode,
    input  logic [1:0]          cmd_size,
    input  logic [DATA_W-1:0]   reg_hi,
    input  logic [DATA_W-1:0]   reg_lo,
    input  logic [DATA_W-1:0]   ext_bytes,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [DATA_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [1:0]          mem_size,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_rdata,
    output logic                done,
    output logic [DATA_W-1:0]   ld_data,
    output logic                ld_to_lo,
    output logic                sp_we,
    output logic [DATA_W-1:0]   sp_new,
    output logic [LEN_W-1:0]    inst_len
);
    localparam int NB = DATA_W / 8;
    localparam int LB = $clog2(NB);

    // Resolved command from the inputs
    logic [DATA_W-1:0] c_addr, c_sval, c_sp;
    logic              c_spwe, c_dlo, c_we;
    size_e             c_size;
    logic [LEN_W-1:0]  c_len;

    lsu_addr_gen #(.DATA_W(DATA_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_addr_gen (
        .op       (op_e'(cmd_op)),
        .mode     (mode_e'(cmd_mode)),
        .size     (size_e'(cmd_size)),
        .reg_hi   (reg_hi),
        .reg_lo   (reg_lo),
        .ext      (ext_bytes),
        .addr     (c_addr),
        .store_val(c_sval),
        .sp_new   (c_sp),
        .sp_we    (c_spwe),
        .dest_lo  (c_dlo),
        .is_write (c_we),
        .eff_size (c_size),
        .len      (c_len)
    );

    state_e st;
    logic   accept_cmd, capture;

    lsu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .state     (st),
        .accept_cmd(accept_cmd),
        .req_valid (mem_req_valid),
        .capture   (capture),
        .done      (done)
    );

    // Command latched at acceptance, held through the whole transaction
    logic [DATA_W-1:0] q_addr, q_sval, q_sp, q_ld;
    logic              q_spwe, q_dlo, q_we;
    size_e             q_size;
    op_e               q_op;
    logic [LEN_W-1:0]  q_len;
    logic [DATA_W-1:0] s_ld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr <= '0;
            q_sval <= '0;
            q_sp   <= '0;
            q_spwe <= 1'b0;
            q_dlo  <= 1'b0;
            q_we   <= 1'b0;
            q_size <= SZ_BYTE;
            q_op   <= OP_LOAD;
            q_len  <= '0;
        end else if (accept_cmd) begin
            q_addr <= c_addr;
            q_sval <= c_sval;
            q_sp   <= c_sp;
            q_spwe <= c_spwe;
            q_dlo  <= c_dlo;
            q_we   <= c_we;
            q_size <= c_size;
            q_op   <= op_e'(cmd_op);
            q_len  <= c_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q_ld <= '0;
        else if (capture) q_ld <= s_ld;
    end

    lsu_lane_steer #(.DATA_W(DATA_W)) u_steer (
        .size     (q_size),
        .ofs      (q_addr[LB-1:0]),
        .store_val(q_sval),
        .rdata    (mem_rsp_rdata),
        .wdata    (mem_wdata),
        .be       (mem_be),
        .ld_val   (s_ld)
    );

    assign mem_addr = q_addr;
    assign mem_we   = q_we;
    assign mem_size = q_size;
    assign ld_data  = q_ld;
    assign ld_to_lo = q_dlo;
    assign sp_we    = q_spwe;
    assign sp_new   = q_sp;
    assign inst_len = q_len;

    // ---------------- properties ----------------
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_wdata));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid));

    p_req_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_valid, done}));

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) && start |=> $stable(mem_addr) && $stable(mem_we));

    p_lane_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ($countones(mem_be) ==
            ((mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : NB)));

    p_push_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && (q_op == OP_PUSH) |-> sp_we && (sp_new == mem_addr) && mem_we);

    p_pop_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && (q_op == OP_POP) |-> sp_we && (sp_new == mem_addr + DATA_W'(NB)) && ld_to_lo);

endmodule

// File: tb/be_lsu_agu_bench.sv
module be_lsu_agu_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RDATA = 32'h8192A3B4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd_op = '0, cmd_mode = '0, cmd_size = '0;
    logic [31:0] reg_hi = '0, reg_lo = '0, ext_bytes = '0;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, ld_data, sp_new;
    logic        mem_we, done, ld_to_lo, sp_we;
    logic [1:0]  mem_size;
    logic [3:0]  mem_be, inst_len;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    be_lsu_agu u_be_lsu_agu (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_op(cmd_op), .cmd_mode(cmd_mode), .cmd_size(cmd_size),
        .reg_hi(reg_hi), .reg_lo(reg_lo), .ext_bytes(ext_bytes),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_size(mem_size),
        .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .done(done), .ld_data(ld_data), .ld_to_lo(ld_to_lo),
        .sp_we(sp_we), .sp_new(sp_new), .inst_len(inst_len)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  mode;
        logic [1:0]  size;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] ext;
        logic [31:0] addr;
        logic        we;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [31:0] ld;
        logic [3:0]  len;
        logic        spwe;
        logic [31:0] sp;
        logic        dsel;
    } vec_t;

    // op: 0 load 1 store 2 push 3 pop; mode: 0 abs 1 ind 2 ofs; size: 0 B 1 H 2 W
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 2'd2, 32'h0, 32'h0, 32'h24010000, 32'h00000124, 1'b0, 32'h0, 4'hF, 32'h8192A3B4, 4'd6, 1'b0, 32'h0, 1'b0},
        '{2'd0, 2'd1, 2'd0, 32'hFFFF, 32'h203, 32'h0, 32'h00000203, 1'b0, 32'h0, 4'h1, 32'h000000B4, 4'd2, 1'b0, 32'h0, 1'b0},
        '{2'd0, 2'd2, 2'd1, 32'h9999, 32'h1000, 32'h0000FEFF, 32'h00000FFE, 1'b0, 32'h0, 4'h3, 32'h0000A3B4, 4'd4, 1'b0, 32'h0, 1'b0},
        '{2'd1, 2'd0, 2'd0, 32'h123456C7, 32'h55, 32'h41000000, 32'h00000041, 1'b1, 32'h00C70000, 4'h4, 32'h0, 4'd6, 1'b0, 32'h0, 1'b0},
        '{2'd1, 2'd1, 2'd1, 32'h300, 32'hDEADBEEF, 32'h0, 32'h00000300, 1'b1, 32'hBEEF0000, 4'hC, 32'h0, 4'd2, 1'b0, 32'h0, 1'b0},
        '{2'd1, 2'd2, 2'd2, 32'h2000, 32'hCAFEF00D, 32'h00000001, 32'h00002100, 1'b1, 32'hCAFEF00D, 4'hF, 32'h0, 4'd4, 1'b0, 32'h0, 1'b0},
        '{2'd2, 2'd0, 2'd0, 32'h400, 32'h11223344, 32'hFFFFFFFF, 32'h000003FC, 1'b1, 32'h11223344, 4'hF, 32'h0, 4'd2, 1'b1, 32'h3FC, 1'b0},
        '{2'd3, 2'd2, 2'd1, 32'h3FC, 32'h0, 32'h0, 32'h000003FC, 1'b0, 32'h0, 4'hF, 32'h8192A3B4, 4'd2, 1'b1, 32'h400, 1'b1},
        '{2'd0, 2'd2, 2'd0, 32'h0, 32'h10, 32'h0000FF7F, 32'h0000800F, 1'b0, 32'h0, 4'h1, 32'h000000B4, 4'd4, 1'b0, 32'h0, 1'b0},
        '{2'd0, 2'd1, 2'd0, 32'h0, 32'h500, 32'h0, 32'h00000500, 1'b0, 32'h0, 4'h8, 32'h00000081, 4'd2, 1'b0, 32'h0, 1'b0},
        '{2'd1, 2'd1, 2'd0, 32'h602, 32'hAB, 32'h0, 32'h00000602, 1'b1, 32'h0000AB00, 4'h2, 32'h0, 4'd2, 1'b0, 32'h0, 1'b0},
        '{2'd0, 2'd1, 2'd1, 32'h0, 32'h700, 32'h0, 32'h00000700, 1'b0, 32'h0, 4'hC, 32'h00008192, 4'd2, 1'b0, 32'h0, 1'b0},
        '{2'd1, 2'd2, 2'd1, 32'h10, 32'h1234, 32'h00000080, 32'hFFFF8010, 1'b1, 32'h12340000, 4'hC, 32'h0, 4'd4, 1'b0, 32'h0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int idx);
        vec_t v;
        v = VECS[idx];
        @(negedge clk);
        cmd_op = v.op; cmd_mode = v.mode; cmd_size = v.size;
        reg_hi = v.hi; reg_lo = v.lo; ext_bytes = v.ext;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_req_valid == 1'b1, "R9 request raised", 32'(mem_req_valid), 32'd1);
        chk(mem_addr == v.addr, "R1/R2/R3/R6/R7 address", mem_addr, v.addr);
        chk(mem_we == v.we, "R8 write flag", 32'(mem_we), 32'(v.we));
        chk(mem_be == v.be, "R4/R5 lane enables", 32'(mem_be), 32'(v.be));
        chk(inst_len == v.len, "R1/R2/R3/R6 length", 32'(inst_len), 32'(v.len));
        if (v.we) chk(mem_wdata == v.wdata, "R4/R6 write data", mem_wdata, v.wdata);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = RDATA;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(done == 1'b1, "R9 done after response", 32'(done), 32'd1);
        chk(sp_we == v.spwe, "R6/R7 stack update flag", 32'(sp_we), 32'(v.spwe));
        if (v.spwe) chk(sp_new == v.sp, "R6/R7 new stack value", sp_new, v.sp);
        if (!v.we) begin
            chk(ld_data == v.ld, "R5/R7 load data", ld_data, v.ld);
            chk(ld_to_lo == v.dsel, "R5/R7 destination", 32'(ld_to_lo), 32'(v.dsel));
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(mem_req_valid == 1'b0, "R11 no request in reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req_valid == 1'b0, "R11 idle after reset", 32'(mem_req_valid), 32'd0);
        chk(done == 1'b0, "R11 done low", 32'(done), 32'd0);
        chk(ld_data == 32'h0, "R11 load data cleared", ld_data, 32'h0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9 stall and R10 stray starts
        @(negedge clk);
        cmd_op = 2'd0; cmd_mode = 2'd0; cmd_size = 2'd2;
        ext_bytes = 32'h24010000; reg_hi = '0; reg_lo = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd_mode = 2'd1; reg_lo = 32'h777;
        for (int c = 0; c < 3; c++) begin
            chk(mem_req_valid == 1'b1, "R9 request held while not ready", 32'(mem_req_valid), 32'd1);
            chk(mem_addr == 32'h124, "R9 address held while not ready", mem_addr, 32'h124);
            start = (c == 1);
            @(negedge clk);
        end
        start = 1'b0;
        chk(mem_addr == 32'h124, "R10 start in REQ ignored", mem_addr, 32'h124);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(mem_req_valid == 1'b0, "R9 request dropped after accept", 32'(mem_req_valid), 32'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R9 no done before response", 32'(done), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R9 no done while waiting", 32'(done), 32'd0);
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = 32'h0F0E0D0C;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(done == 1'b1, "R9 done after delayed response", 32'(done), 32'd1);
        chk(ld_data == 32'h0F0E0D0C, "R10 result of first command", ld_data, 32'h0F0E0D0C);
        chk(mem_addr == 32'h124, "R10 address unchanged", mem_addr, 32'h124);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(mem_req_valid == 1'b0, "R10 no queued request", 32'(mem_req_valid), 32'd0);
            chk(done == 1'b0, "R9 done stays low", 32'(done), 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule